// File: doc/BRIEF.md
# Grouped Completion Interrupt Aggregator

This block turns per-slot completion flags from three transfer tables into interrupt requests. The three tables hold isochronous, interrupt-transfer and asynchronous work. Each table presents one done flag per slot. Each table also has two selection masks. The all-of mask raises the table's request when every selected slot is done. The any-of mask raises it when at least one selected slot is done. Either condition is enough.

A fourth source follows the microframe tick, a single-cycle pulse that arrives once every 125 µs. Delivery of the three table requests can be deferred by a programmable count of microframe ticks. All four sources land in sticky status bits that are cleared by writing one. A single combined interrupt line reports every status bit that is enabled.

Top module: `irq_group_agg`

## Requirements
- R1: When a table's all-of mask is nonzero and every slot it selects is done, that table's status bit is set.
- R2: The all-of condition is false when any selected slot is not done, and it is always false when the mask is zero.
- R3: A table's status bit is set when any slot selected by its any-of mask is done. Done flags of slots outside both masks have no effect.
- R4: Status bit 0 belongs to the isochronous table, bit 1 to the interrupt-transfer table, bit 2 to the asynchronous table and bit 3 to the microframe source. Table t uses bits [t*SLOTS +: SLOTS] of the done, all-of and any-of vectors. A table's condition sets only its own bit.
- R5: A status bit stays set after its condition goes away.
- R6: A one in bit k of `clear_i` clears status bit k at the next edge. When the set condition is active in the same cycle, the set wins.
- R7: Status bit 3 is set at the edge that samples a `uframe_tick_i` pulse.
- R8: With latency 0, a table's status bit is set at the first clock edge that samples its condition as true.
- R9: With latency N>0, a table's condition arms a timer. The ticks that follow are counted, not including a tick in the arming cycle. The status bit is set at the edge that samples the Nth tick, and not before.
- R10: `irq_o` is the OR of `status_o & enable_i` and follows a change of `enable_i` without waiting for a clock edge.
- R11: After reset, every status bit and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| done_i | input | 3*SLOTS | Done flags for all three tables; table t is at [t*SLOTS +: SLOTS] |
| all_mask_i | input | 3*SLOTS | All-of selection masks, laid out the same way |
| any_mask_i | input | 3*SLOTS | Any-of selection masks, laid out the same way |
| latency_i | input | LAT_W | Deferral, in microframe ticks, for the table requests |
| uframe_tick_i | input | 1 | Microframe tick, one cycle wide |
| clear_i | input | 4 | Write-one-to-clear strobes, one per status bit |
| enable_i | input | 4 | Per-source enable for the combined line |
| status_o | output | 4 | Sticky status bits |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench looks at an all-of group that is only partly done and at an all-of mask of zero with every slot done. A design that ignored the nonzero rule would fire on the zero mask, and one that reduced the wrong way would fire on the partial group. It sets done flags outside both masks, checks that a strobe arriving with an active condition does not clear the bit, and checks that only the addressed table's bit rises. With a latency of three it samples the status after two ticks and again after the third. An off-by-one counter, or a design that counts the tick in the arming cycle, would deliver one tick early or late. The enable mask is changed between clock edges to catch a registered or wrongly masked combined line.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int XFER_TABLES = 3;
   localparam int SRC_COUNT   = XFER_TABLES + 1;

   typedef enum logic [1:0] {
      SRC_ISOC  = 2'd0,
      SRC_INTR  = 2'd1,
      SRC_ASYNC = 2'd2,
      SRC_FRAME = 2'd3
   } irq_src_e;

endpackage

// File: rtl/irq_group_eval.sv
// Evaluates the all-of and any-of grouping conditions for one table.
module irq_group_eval #(
   parameter int SLOTS = 32
) (
   input  logic [SLOTS-1:0] done_i,
   input  logic [SLOTS-1:0] all_mask_i,
   input  logic [SLOTS-1:0] any_mask_i,
   output logic             all_hit_o,
   output logic             any_hit_o,
   output logic             cond_o
);

   if (SLOTS < 1 || SLOTS > 64) begin : g_bad_slots
      $error("irq_group_eval: SLOTS must lie in 1..64");
   end

   logic [SLOTS-1:0] missing;
   logic [SLOTS-1:0] hits;

   always_comb begin
      missing   = all_mask_i & ~done_i;
      hits      = any_mask_i & done_i;
      all_hit_o = (|all_mask_i) && !(|missing);
      any_hit_o = |hits;
      cond_o    = all_hit_o | any_hit_o;
   end

endmodule

// File: rtl/irq_defer.sv
// Holds a table request back for a programmable number of microframe ticks.
module irq_defer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cond_i,
   input  logic             tick_i,
   input  logic [LAT_W-1:0] latency_i,
   output logic             fire_o
);

   if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
      $error("irq_defer: LAT_W must lie in 1..16");
   end

   localparam int CW = LAT_W + 1;

   logic             armed_q;
   logic [LAT_W-1:0] cnt_q;
   logic [CW-1:0]    cnt_next;
   logic             reached;
   logic             lat_zero;

   always_comb begin
      lat_zero = (latency_i == '0);
      cnt_next = {1'b0, cnt_q} + CW'(1);
      reached  = (cnt_next >= {1'b0, latency_i});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (!armed_q) begin
         if (cond_i && !lat_zero) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end
      end else if (tick_i) begin
         if (reached) armed_q <= 1'b0;
         cnt_q <= cnt_next[LAT_W-1:0];
      end
   end

   always_comb begin
      if (lat_zero) fire_o = cond_i;
      else          fire_o = armed_q && tick_i && reached;
   end

   // R9
   fire_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !lat_zero) |-> armed_q);

endmodule

// File: rtl/irq_status_bit.sv
// One sticky, write-one-to-clear status bit; a set in the same cycle wins.
module irq_status_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_i);
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   // R6
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);

   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
   import irq_agg_pkg::*;
#(
   parameter int SLOTS      = 32,
   parameter int LAT_W      = 8,
   parameter bit DEFER_EN   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [XFER_TABLES*SLOTS-1:0] done_i,
   input  logic [XFER_TABLES*SLOTS-1:0] all_mask_i,
   input  logic [XFER_TABLES*SLOTS-1:0] any_mask_i,
   input  logic [LAT_W-1:0]             latency_i,
   input  logic                         uframe_tick_i,
   input  logic [SRC_COUNT-1:0]         clear_i,
   input  logic [SRC_COUNT-1:0]         enable_i,
   output logic [SRC_COUNT-1:0]         status_o,
   output logic                         irq_o
);

   logic [XFER_TABLES-1:0] cond;
   logic [XFER_TABLES-1:0] all_hit;
   logic [XFER_TABLES-1:0] any_hit;
   logic [SRC_COUNT-1:0]   set_req;

   for (genvar t = 0; t < XFER_TABLES; t++) begin : g_table
      irq_group_eval #(.SLOTS(SLOTS)) u_eval (
         .done_i     (done_i[t*SLOTS +: SLOTS]),
         .all_mask_i (all_mask_i[t*SLOTS +: SLOTS]),
         .any_mask_i (any_mask_i[t*SLOTS +: SLOTS]),
         .all_hit_o  (all_hit[t]),
         .any_hit_o  (any_hit[t]),
         .cond_o     (cond[t])
      );

      if (DEFER_EN) begin : g_defer
         irq_defer #(.LAT_W(LAT_W)) u_defer (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond_i    (cond[t]),
            .tick_i    (uframe_tick_i),
            .latency_i (latency_i),
            .fire_o    (set_req[t])
         );
      end else begin : g_direct
         assign set_req[t] = cond[t];
      end
   end

   assign set_req[SRC_FRAME] = uframe_tick_i;

   for (genvar s = 0; s < SRC_COUNT; s++) begin : g_status
      irq_status_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_req[s]),
         .clr_i (clear_i[s]),
         .q_o   (status_o[s])
      );
   end

   assign irq_o = |(status_o & enable_i);

   // R7
   frame_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uframe_tick_i |=> status_o[SRC_FRAME]);

   // R1
   all_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (all_hit[SRC_INTR] && latency_i == '0) |=> status_o[SRC_INTR]);

   // R3
   any_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_hit[SRC_ASYNC] && latency_i == '0) |=> status_o[SRC_ASYNC]);

   // R11
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (status_o == '0));

endmodule

// File: tb/irq_group_agg_test.sv
module irq_group_agg_test;
   localparam int S = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3*S-1:0] done = '0, amask = '0, omask = '0;
   logic [7:0]    lat = '0;
   logic          tick = 1'b0;
   logic [3:0]    clr = '0, en = '0;
   logic [3:0]    status;
   logic          irq;
   int            checks = 0, fails = 0;

   always #2 clk = ~clk;

   irq_group_agg uut (
      .clk(clk), .rst_n(rst_n), .done_i(done), .all_mask_i(amask),
      .any_mask_i(omask), .latency_i(lat), .uframe_tick_i(tick),
      .clear_i(clr), .enable_i(en), .status_o(status), .irq_o(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic clean();
      done = '0; amask = '0; omask = '0; tick = 1'b0; lat = '0;
      clr = 4'hF; step(); clr = '0; step();
   endtask

   task automatic t_reset();
      check("R11 status", 32'(status), 0);
      check("R11 irq", 32'(irq), 0);
   endtask

   task automatic t_all_group();
      clean();
      amask[1*S +: S] = 32'h0000_00F0;
      done[1*S +: S]  = 32'h0000_0070;
      step();
      check("R2 partial group", 32'(status), 0);
      done[1*S +: S] = 32'h0000_00F0;
      step();
      check("R1 R8 full group", 32'(status), 32'h2);
      clean();
      done = '1;
      step(); step();
      check("R2 zero mask", 32'(status), 0);
   endtask

   task automatic t_any_group();
      clean();
      omask[2*S +: S] = 32'h8000_0001;
      done[2*S +: S]  = 32'h0000_0100;
      step();
      check("R3 unmasked ignored", 32'(status), 0);
      done[2*S +: S] = 32'h8000_0000;
      step();
      check("R3 R4 any hit", 32'(status), 32'h4);
      done = '0;
      step(); step();
      check("R5 sticky", 32'(status), 32'h4);
      clr = 4'b0100; step(); clr = '0;
      check("R6 clear", 32'(status), 0);
      done[2*S +: S] = 32'h0000_0001;
      clr = 4'b0100; step(); clr = '0;
      check("R6 set wins", 32'(status), 32'h4);
   endtask

   task automatic t_frame_irq();
      clean();
      tick = 1'b1; step(); tick = 1'b0;
      check("R7 frame bit", 32'(status), 32'h8);
      en = 4'b0111; #1;
      check("R10 masked", 32'(irq), 0);
      en = 4'b1000; #1;
      check("R10 enabled", 32'(irq), 1);
      en = 4'b0000; #1;
      check("R10 disabled", 32'(irq), 0);
   endtask

   task automatic t_latency();
      clean();
      lat = 8'd3;
      omask[0 +: S] = 32'h1;
      done[0 +: S]  = 32'h1;
      step();
      check("R9 armed no fire", 32'(status[0]), 0);
      for (int i = 0; i < 2; i++) begin
         tick = 1'b1; step(); tick = 1'b0; step();
      end
      check("R9 after two ticks", 32'(status[0]), 0);
      tick = 1'b1; step(); tick = 1'b0;
      check("R9 third tick", 32'(status[0]), 1);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_all_group();
            t_any_group();
            t_frame_irq();
            t_latency();
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule